// File: doc/BRIEF.md
# Watchdog Timer with Keyed Feed

This block is a supervisory timer for a small processor subsystem. A divider and a prescaler turn one of two clock-enable sources into a slow tick. That tick decrements an 8-bit down counter. Software keeps the counter from running out by writing a two-byte key. If the counter runs past zero while the reset function is enabled, the block emits a one-cycle system reset pulse. With the reset function disabled, the same underflow raises an interval interrupt and sets a sticky timeout flag instead.

Configuration changes are guarded. A write to the control register only fills a shadow copy. The copy becomes active on the next correctly keyed feed. A malformed key sequence, or a control write that the key does not follow at once, is treated as a fault and fires the reset. The configuration and the reload value are cleared only by the power-on reset input. The pulses the block generates itself leave them in place.

Top module: `wdt_keyed`

## Requirements
- R1: While `por` is high and on the first cycle after it, `wdt_rst`, `tmr_irq`, `tmo_flag` and `counting` are 0. The active and shadow configuration come up stopped, in timer mode, with the divided peripheral clock as source and tap 0.
- R2: Writing 0xA5 to address 2, with the next register write being 0x5A to address 3, is a valid feed. A valid feed copies the shadow configuration into the active one, loads the down counter from the reload register (address 1) and clears the divider and prescaler. A valid feed causes no reset.
- R3: A write to address 0 changes only the shadow configuration. Its fields are: bit 0 run, bit 1 reset enable, bit 2 source (1 = slow oscillator enable, 0 = peripheral enable divided by PCLK_DIV), and bits [4+SEL_W-1:4] tap. The active behaviour, including `counting`, stays unchanged until a valid feed.
- R4: Tap k decrements the counter once every 2^(PRE_W-2^SEL_W+k+1) source ticks. With reload R, the counter underflows (R+1) such periods after a feed.
- R5: With the peripheral source selected, one source tick occurs for every PCLK_DIV cycles in which `pclk_en` is high.
- R6: In watchdog mode (reset enable = 1), an underflow drives `wdt_rst` high for exactly one cycle, on the cycle after the edge at which the counter passes zero. That same edge reloads the counter and clears the prescaler.
- R7: In watchdog mode, each of the following raises `wdt_rst` on the cycle after the offending write:
  - a write to address 2 with a value other than 0xA5;
  - a write to address 3 that does not follow 0xA5 directly;
  - any write after 0xA5 other than 0x5A to address 3;
  - a control write followed by anything other than 0xA5 to address 2.
- R8: In timer mode (reset enable = 0), an underflow pulses `tmr_irq` for one cycle and sets `tmo_flag`, which then stays set. Neither underflows nor key errors raise `wdt_rst` in this mode.
- R9: A control write with bit 7 = 0 clears `tmo_flag` at once, without waiting for a feed. If an underflow happens on the same edge, setting the flag wins.
- R10: With the peripheral source selected and `pwr_down` high, the prescaler and counter hold and `counting` reads 0. With the oscillator source selected, `pwr_down` has no effect.
- R11: Resets the block generates itself leave the active configuration, shadow and reload register unchanged, so the next period repeats with the same timing.
- R12: `wdt_rst` and `tmr_irq` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| pclk_en | input | 1 | Peripheral clock enable pulse |
| wosc_en | input | 1 | Slow watchdog oscillator enable pulse |
| pwr_down | input | 1 | Power-down state of the system |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 reload, 2 first key, 3 second key |
| wr_data | input | 8 | Write data |
| wdt_rst | output | 1 | One-cycle system reset request |
| tmr_irq | output | 1 | One-cycle interval interrupt (timer mode) |
| tmo_flag | output | 1 | Sticky timeout flag |
| counting | output | 1 | Registered: prescaler is advancing |

## Verification
Some properties are checked by assertions on every cycle:
- the counter holds when no tap tick or load arrives;
- a valid feed loads the reload value;
- the peripheral source halts counting under power-down;
- an interrupt implies the timeout flag;
- reset and interrupt never coincide.

The exact underflow period for each tap and reload value, the pclk divide, the shadow-until-feed rule, each class of key fault, flag stickiness and clearing, and the retention of the configuration across generated resets are shown only by the bench's timed scenarios.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    A_CTRL   = 2'd0,
    A_RELOAD = 2'd1,
    A_KEY1   = 2'd2,
    A_KEY2   = 2'd3
  } wdt_addr_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_KEYED = 2'd1,
    SQ_PEND  = 2'd2
  } wdt_seq_e;

  localparam logic [7:0] KEY_FIRST  = 8'hA5;
  localparam logic [7:0] KEY_SECOND = 8'h5A;
endpackage

// File: rtl/wdt_feed_seq.sv
module wdt_feed_seq
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       abort,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       feed_ok,
  output logic       seq_err
);
  wdt_seq_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    feed_ok = 1'b0;
    seq_err = 1'b0;
    if (wr_en) begin
      case (state_q)
        SQ_IDLE: begin
          if (wr_addr == A_KEY1) begin
            if (wr_data == KEY_FIRST) state_d = SQ_KEYED;
            else seq_err = 1'b1;
          end else if (wr_addr == A_KEY2) begin
            seq_err = 1'b1;
          end else if (wr_addr == A_CTRL) begin
            state_d = SQ_PEND;
          end
        end
        SQ_KEYED: begin
          state_d = SQ_IDLE;
          if (wr_addr == A_KEY2 && wr_data == KEY_SECOND) feed_ok = 1'b1;
          else seq_err = 1'b1;
        end
        SQ_PEND: begin
          if (wr_addr == A_KEY1 && wr_data == KEY_FIRST) state_d = SQ_KEYED;
          else begin
            seq_err = 1'b1;
            state_d = SQ_IDLE;
          end
        end
        default: state_d = SQ_IDLE;
      endcase
    end
    if (abort) state_d = SQ_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= SQ_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/wdt_clk_tap.sv
module wdt_clk_tap #(
  parameter int PRE_W    = 12,
  parameter int SEL_W    = 3,
  parameter int PCLK_DIV = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             use_osc,
  input  logic             pclk_en,
  input  logic             wosc_en,
  input  logic [SEL_W-1:0] tap_sel,
  output logic             tap_tick
);
  localparam int DIV_W    = (PCLK_DIV > 1) ? $clog2(PCLK_DIV) : 1;
  localparam int TAP_BASE = PRE_W - (1 << SEL_W);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(PCLK_DIV - 1);
  localparam logic [DIV_W-1:0] DIV_ONE  = DIV_W'(1);
  localparam logic [PRE_W-1:0] PRE_ONE  = PRE_W'(1);

  logic [DIV_W-1:0] div_q;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] carry_mask;
  logic             div_tick, src_tick;

  assign div_tick = pclk_en && (div_q == DIV_LAST);
  assign src_tick = use_osc ? wosc_en : div_tick;

  always_comb begin
    for (int i = 0; i < PRE_W; i++)
      carry_mask[i] = (i <= TAP_BASE + int'(tap_sel));
  end

  assign tap_tick = en && src_tick && (&(pre_q | ~carry_mask));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      div_q <= '0;
      pre_q <= '0;
    end else if (en) begin
      if (pclk_en) div_q <= div_tick ? '0 : div_q + DIV_ONE;
      if (src_tick) pre_q <= pre_q + PRE_ONE;
    end
  end

  // R10: a halted prescaler keeps its value
  assert_prescaler_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(pre_q));
endmodule

// File: rtl/wdt_downcnt.sv
module wdt_downcnt #(
  parameter int CNT_W = 8,
  parameter logic [CNT_W-1:0] INIT = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             uf
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  assign uf = tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= INIT;
    else if (load) cnt <= reload;
    else if (tick) cnt <= (cnt == '0) ? reload : cnt - CNT_ONE;
  end

  // R4: the counter moves only on a tap tick or a load
  assert_count_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(cnt));
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter int PRE_W    = 12,
  parameter int SEL_W    = 3,
  parameter int CNT_W    = 8,
  parameter int PCLK_DIV = 32,
  parameter logic [7:0] RELOAD_INIT = 8'hFF
) (
  input  logic       clk,
  input  logic       por,
  input  logic       pclk_en,
  input  logic       wosc_en,
  input  logic       pwr_down,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       wdt_rst,
  output logic       tmr_irq,
  output logic       tmo_flag,
  output logic       counting
);
  localparam logic [CNT_W-1:0] CNT_INIT = RELOAD_INIT[CNT_W-1:0];

  logic             sh_run, sh_rst_en, sh_osc;
  logic [SEL_W-1:0] sh_tap;
  logic             act_run, act_rst_en, act_osc;
  logic [SEL_W-1:0] act_tap;
  logic [CNT_W-1:0] reload_q, cnt;
  logic             feed_ok, seq_err, tap_tick, uf, uf_ev, wd_fire, run_eff;
  logic             ctrl_wr, reload_wr, restart;

  assign ctrl_wr   = wr_en && (wr_addr == A_CTRL);
  assign reload_wr = wr_en && (wr_addr == A_RELOAD);
  assign run_eff   = act_run && !(pwr_down && !act_osc);
  assign uf_ev     = uf && !feed_ok;
  assign wd_fire   = act_rst_en && (uf_ev || seq_err);
  assign restart   = feed_ok || wd_fire;

  wdt_feed_seq u_seq (
    .clk(clk), .rst(por), .abort(wd_fire),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .feed_ok(feed_ok), .seq_err(seq_err)
  );

  wdt_clk_tap #(.PRE_W(PRE_W), .SEL_W(SEL_W), .PCLK_DIV(PCLK_DIV)) u_tap (
    .clk(clk), .rst(por), .clr(restart), .en(run_eff), .use_osc(act_osc),
    .pclk_en(pclk_en), .wosc_en(wosc_en), .tap_sel(act_tap), .tap_tick(tap_tick)
  );

  wdt_downcnt #(.CNT_W(CNT_W), .INIT(CNT_INIT)) u_cnt (
    .clk(clk), .rst(por), .load(restart), .tick(tap_tick),
    .reload(reload_q), .cnt(cnt), .uf(uf)
  );

  always_ff @(posedge clk) begin
    if (por) begin
      sh_run <= 1'b0; sh_rst_en <= 1'b0; sh_osc <= 1'b0; sh_tap <= '0;
      act_run <= 1'b0; act_rst_en <= 1'b0; act_osc <= 1'b0; act_tap <= '0;
      reload_q <= CNT_INIT;
      tmo_flag <= 1'b0;
      wdt_rst  <= 1'b0;
      tmr_irq  <= 1'b0;
      counting <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        sh_run    <= wr_data[0];
        sh_rst_en <= wr_data[1];
        sh_osc    <= wr_data[2];
        sh_tap    <= wr_data[4 +: SEL_W];
      end
      if (reload_wr) reload_q <= wr_data[CNT_W-1:0];
      if (feed_ok) begin
        act_run    <= sh_run;
        act_rst_en <= sh_rst_en;
        act_osc    <= sh_osc;
        act_tap    <= sh_tap;
      end
      if (uf_ev) tmo_flag <= 1'b1;
      else if (ctrl_wr && !wr_data[7]) tmo_flag <= 1'b0;
      wdt_rst  <= wd_fire;
      tmr_irq  <= uf_ev && !act_rst_en;
      counting <= run_eff;
    end
  end

  // R2: a valid feed reloads the counter
  assert_feed_reload_R2: assert property (@(posedge clk) disable iff (por)
    feed_ok |=> (cnt == $past(reload_q)));
  // R10: peripheral source under power-down stops counting
  assert_pwrdown_halt_R10: assert property (@(posedge clk) disable iff (por)
    (pwr_down && !act_osc) |=> !counting);
  // R8: an interrupt always comes with the timeout flag
  assert_irq_flag_R8: assert property (@(posedge clk) disable iff (por)
    tmr_irq |-> tmo_flag);
  // R12: reset and interrupt are exclusive
  assert_rst_irq_excl_R12: assert property (@(posedge clk) disable iff (por)
    !(wdt_rst && tmr_irq));
endmodule

// File: tb/wdt_keyed_bench.sv
module wdt_keyed_bench;
  localparam int PRE_W = 6, SEL_W = 2, CNT_W = 8, PCLK_DIV = 4;
  localparam int TAP_BASE = PRE_W - (1 << SEL_W);

  logic clk = 1'b0, por = 1'b1, pclk_en = 1'b1, wosc_en = 1'b1, pwr_down = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic wdt_rst, tmr_irq, tmo_flag, counting;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdt_keyed #(.PRE_W(PRE_W), .SEL_W(SEL_W), .CNT_W(CNT_W), .PCLK_DIV(PCLK_DIV)) u_wdt_keyed (
    .clk(clk), .por(por), .pclk_en(pclk_en), .wosc_en(wosc_en), .pwr_down(pwr_down),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wdt_rst(wdt_rst), .tmr_irq(tmr_irq), .tmo_flag(tmo_flag), .counting(counting)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the following posedge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [7:0] ctl(input bit run, input bit rsten, input bit osc,
                                     input int tap, input bit keep);
    logic [2:0] t = 3'(tap);
    return {keep, t, 1'b0, osc, rsten, run};
  endfunction

  task automatic cfg(input bit run, input bit rsten, input bit osc, input int tap, input int rl);
    wr(2'd1, 8'(rl));
    wr(2'd0, ctl(run, rsten, osc, tap, 1'b1));
    wr(2'd2, 8'hA5);
    wr(2'd3, 8'h5A);
  endtask

  task automatic wait_evt(input bit irq_sel, input int limit, output int n);
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (irq_sel ? tmr_irq : wdt_rst) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic expect_fault(input string req);
    chk(req, int'(wdt_rst), 1);
    @(negedge clk);
    chk("R6 pulse width", int'(wdt_rst), 0);
    chk("R11 config kept", int'(counting), 1);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    int rl[3] = '{0, 2, 5};
    repeat (3) @(negedge clk);
    chk("R1 rst in reset", int'(wdt_rst), 0);
    por = 1'b0;
    @(negedge clk);
    chk("R1 rst", int'(wdt_rst), 0);
    chk("R1 irq", int'(tmr_irq), 0);
    chk("R1 flag", int'(tmo_flag), 0);
    chk("R1 counting", int'(counting), 0);
    wait_evt(1'b1, 60, n);
    chk("R1 stopped no irq", n, 0);
    wr(2'd3, 8'h33);
    chk("R8 fault ignored in timer mode", int'(wdt_rst), 0);

    // tap and reload sweep, oscillator source, watchdog mode
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < 3; j++) begin
        cfg(1'b1, 1'b1, 1'b1, k, rl[j]);
        chk("R2 valid feed no reset", int'(wdt_rst), 0);
        wait_evt(1'b0, 2000, n);
        chk("R4 R6 underflow period", n, (rl[j] + 1) * (1 << (TAP_BASE + k + 1)));
      end
    end
    wait_evt(1'b0, 2000, n);
    chk("R11 period repeats", n, 6 * (1 << (TAP_BASE + 4)));

    // key faults in watchdog mode
    cfg(1'b1, 1'b1, 1'b1, 3, 200);
    @(negedge clk);
    chk("R2 no reset after feed", int'(wdt_rst), 0);
    chk("R3 feed applies run", int'(counting), 1);
    wr(2'd2, 8'h00);                expect_fault("R7 wrong first key");
    wr(2'd3, 8'h5A);                expect_fault("R7 second key alone");
    wr(2'd2, 8'hA5);
    chk("R7 first key alone no reset", int'(wdt_rst), 0);
    wr(2'd1, 8'd200);               expect_fault("R7 write between keys");
    wr(2'd2, 8'hA5); wr(2'd3, 8'h11); expect_fault("R7 wrong second key");
    wr(2'd0, ctl(1, 1, 1, 3, 1'b1));
    chk("R7 ctrl write alone no reset yet", int'(wdt_rst), 0);
    wr(2'd1, 8'd200);               expect_fault("R7 ctrl write not fed");
    wr(2'd0, ctl(1, 1, 1, 3, 1'b1));
    wr(2'd2, 8'h5A);                expect_fault("R7 ctrl write bad key");

    // timer mode
    cfg(1'b1, 1'b0, 1'b1, 0, 1);
    wait_evt(1'b1, 2000, n);
    chk("R8 irq period", n, 2 * (1 << (TAP_BASE + 1)));
    chk("R8 flag set", int'(tmo_flag), 1);
    chk("R12 no reset with irq", int'(wdt_rst), 0);
    @(negedge clk);
    chk("R8 irq one cycle", int'(tmr_irq), 0);
    chk("R8 flag sticky", int'(tmo_flag), 1);
    wr(2'd0, ctl(0, 0, 1, 0, 1'b0));
    chk("R9 flag cleared", int'(tmo_flag), 0);
    chk("R3 shadow not applied", int'(counting), 1);
    @(negedge clk);
    chk("R3 shadow still pending", int'(counting), 1);
    wr(2'd2, 8'hA5); wr(2'd3, 8'h5A);
    @(negedge clk);
    chk("R3 applied on feed", int'(counting), 0);
    wr(2'd3, 8'h11);
    chk("R8 fault ignored", int'(wdt_rst), 0);

    // peripheral source and power-down
    cfg(1'b1, 1'b1, 1'b0, 1, 1);
    wait_evt(1'b0, 2000, n);
    chk("R5 pclk period", n, 2 * (1 << (TAP_BASE + 2)) * PCLK_DIV);
    pwr_down = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R10 counting off", int'(counting), 0);
    wait_evt(1'b0, 300, n);
    chk("R10 no underflow in power-down", n, 0);
    pwr_down = 1'b0;
    wait_evt(1'b0, 300, n);
    chk("R10 resumes", int'(n > 0), 1);
    pwr_down = 1'b1;
    cfg(1'b1, 1'b1, 1'b1, 0, 1);
    wait_evt(1'b0, 2000, n);
    chk("R10 osc ignores power-down", n, 2 * (1 << (TAP_BASE + 1)));
    chk("R10 counting on", int'(counting), 1);
    pwr_down = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule